// File: doc/BRIEF.md
# Capture/Fetch Burst Arbiter with Pending-Block Counter

This block lets two Wishbone-style masters share one memory port. The capture master stores freshly acquired sample blocks. The fetch master pulls stored blocks back out and pushes them toward a dual-clock FIFO that feeds the host link. The capture side always has priority, so real-time capture is never stalled by host traffic. Once a master is granted, it keeps the port for a full block of `BLOCK_WORDS` acknowledged beats, which is 8 by default.

Alongside the arbitration, the block tracks two quantities. The first is the number of blocks stored but not yet fetched. The second is the number of blocks the current transfer still has to move; it is loaded by a start pulse. From these and the free space reported by the FIFO, the block produces a permit that tells the fetch master when it may request a block. The arbiter also refuses to grant a fetch burst while that permit is low.

The grant state machine has three states. `ARB_IDLE` means no grant is held. `ARB_CAPTURE` means the capture master owns the port. `ARB_FETCH` means the fetch master owns the port. From `ARB_IDLE` the machine moves to `ARB_CAPTURE` whenever capture requests. It moves to `ARB_FETCH` only when capture is silent, fetch requests and the permit is high. Otherwise it stays in `ARB_IDLE`. Both burst states return to `ARB_IDLE` on the last acknowledged beat of the block and hold their state on every other cycle. Because every burst passes back through `ARB_IDLE`, the port is idle for one cycle between bursts.

Top module: `capfetch_arbiter`

## Requirements
- R1: After reset the arbiter is in `ARB_IDLE`: `mem_cyc` is 0, `pend_count` is 0, `xfer_done` is 1 (the remaining count is 0) and `fet_permit` is 0.
- R2: If both masters raise `cyc` and `stb` while the port is idle, the capture master is granted. Its beats are acknowledged first (`cap_ack`) and the fetch master sees no `fet_ack` until the capture block has ended.
- R3: A granted master keeps the port until its `BLOCK_WORDS`-th acknowledged beat. A request from the other master during that burst is not served until the burst ends, and `cap_ack` and `fet_ack` are never high together.
- R4: `pend_count` rises by one on the clock edge that takes the last acknowledged beat of a capture block.
- R5: `pend_count` falls by one on the clock edge that takes the last acknowledged beat of a fetch block. When a capture block and a fetch block end on the same edge, the count is unchanged.
- R6: `fet_permit` is high exactly when all three of these hold: `pend_count` is non-zero, `xfer_done` is 0, and `fifo_free` is at least `BLOCK_WORDS`.
- R7: While `fet_permit` is low, a fetch request from the idle state is not granted: `mem_cyc` stays 0 and no `fet_ack` is produced.
- R8: A `start` pulse loads the remaining-block count from `total_blocks`. Each completed fetch block lowers the count by one, stopping at zero. `xfer_done` is high when the count is zero, and a later `start` reloads it.
- R9: Capture blocks are still granted and counted while `xfer_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the remaining-block count |
| total_blocks | input | XFER_W | Number of blocks to fetch in this transfer |
| fifo_free | input | FREE_W | Free words in the downstream dual-clock FIFO |
| cap_cyc | input | 1 | Capture master cycle |
| cap_stb | input | 1 | Capture master strobe |
| cap_adr | input | ADDR_W | Capture master address |
| cap_dat | input | DATA_W | Capture master write data |
| cap_ack | output | 1 | Beat acknowledge to capture master |
| fet_cyc | input | 1 | Fetch master cycle |
| fet_stb | input | 1 | Fetch master strobe |
| fet_adr | input | ADDR_W | Fetch master address |
| fet_dat | output | DATA_W | Read data to fetch master |
| fet_ack | output | 1 | Beat acknowledge to fetch master |
| fet_permit | output | 1 | Fetch master may request a block |
| mem_cyc | output | 1 | Shared port cycle |
| mem_stb | output | 1 | Shared port strobe |
| mem_we | output | 1 | Shared port write enable (capture grant) |
| mem_adr | output | ADDR_W | Shared port address |
| mem_wdat | output | DATA_W | Shared port write data |
| mem_rdat | input | DATA_W | Shared port read data |
| mem_ack | input | 1 | Shared port beat acknowledge |
| pend_count | output | PEND_W | Blocks stored but not yet fetched |
| xfer_done | output | 1 | Remaining-block count is zero |

## Verification
The permit logic is driven through a table of cases. Each case sets the pending count, the remaining count and the FIFO free space, and the cases isolate each of the three conditions. One row sits one word below the free-space threshold and another sits exactly on it, which separates a `>=` comparison from `>`. Arbitration is tried with both requests raised on the same cycle, and separately with capture arriving three cycles into a fetch burst. The first case exposes a wrong priority. The second exposes a grant that can be taken away before the block ends. The count paths are driven through a run that drains the transfer to zero and then reloads it, with an extra capture in between. This distinguishes the remaining counter from the pending counter and shows that a finished transfer does not block capture.

// File: rtl/capfetch_pkg.sv
package capfetch_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_CAPTURE = 2'd1,
        ARB_FETCH   = 2'd2
    } arb_state_t;

endpackage

// File: rtl/capfetch_fsm.sv
module capfetch_fsm
    import capfetch_pkg::*;
#(
    parameter int BLOCK_WORDS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_req,
    input  logic       fet_req,
    input  logic       fet_permit,
    input  logic       mem_ack,
    output arb_state_t state,
    output logic       burst_end,
    output logic       cap_blk_done,
    output logic       fet_blk_done
);

    localparam int BEAT_W = $clog2(BLOCK_WORDS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLOCK_WORDS - 1);

    arb_state_t        state_nxt;
    logic [BEAT_W-1:0] beat;

    // burst ends on the acknowledged beat carrying the last word of the block
    assign burst_end = (state != ARB_IDLE) && mem_ack && (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state == ARB_IDLE) begin
            beat <= '0;
        end else if (mem_ack) begin
            beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARB_IDLE: begin
                if (cap_req) begin
                    state_nxt = ARB_CAPTURE;
                end else if (fet_req && fet_permit) begin
                    state_nxt = ARB_FETCH;
                end
            end
            ARB_CAPTURE: begin
                if (burst_end) state_nxt = ARB_IDLE;
            end
            ARB_FETCH: begin
                if (burst_end) state_nxt = ARB_IDLE;
            end
            default: state_nxt = ARB_IDLE;
        endcase
    end

    always_comb begin
        cap_blk_done = 1'b0;
        fet_blk_done = 1'b0;
        unique case (state)
            ARB_IDLE:    ;
            ARB_CAPTURE: cap_blk_done = burst_end;
            ARB_FETCH:   fet_blk_done = burst_end;
            default:     ;
        endcase
    end

endmodule

// File: rtl/capfetch_blkcnt.sv
module capfetch_blkcnt #(
    parameter int PEND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (!(&count)) count <= count + 1'b1;
                2'b01: if (count != '0) count <= count - 1'b1;
                default: ;   // idle, or store and fetch ending together
            endcase
        end
    end

endmodule

// File: rtl/capfetch_xfer.sv
module capfetch_xfer #(
    parameter int XFER_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [XFER_W-1:0] load_val,
    input  logic              dec,
    output logic              done
);

    logic [XFER_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign done = (remaining == '0);

endmodule

// File: rtl/capfetch_arbiter.sv
module capfetch_arbiter
    import capfetch_pkg::*;
#(
    parameter int BLOCK_WORDS = 8,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int PEND_W      = 16,
    parameter int XFER_W      = 32,
    parameter int FREE_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XFER_W-1:0] total_blocks,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              cap_cyc,
    input  logic              cap_stb,
    input  logic [ADDR_W-1:0] cap_adr,
    input  logic [DATA_W-1:0] cap_dat,
    output logic              cap_ack,
    input  logic              fet_cyc,
    input  logic              fet_stb,
    input  logic [ADDR_W-1:0] fet_adr,
    output logic [DATA_W-1:0] fet_dat,
    output logic              fet_ack,
    output logic              fet_permit,
    output logic              mem_cyc,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_adr,
    output logic [DATA_W-1:0] mem_wdat,
    input  logic [DATA_W-1:0] mem_rdat,
    input  logic              mem_ack,
    output logic [PEND_W-1:0] pend_count,
    output logic              xfer_done
);

    localparam logic [FREE_W-1:0] ROOM_NEEDED = FREE_W'(BLOCK_WORDS);

    logic       cap_req;
    logic       fet_req;
    arb_state_t state;
    logic       burst_end;
    logic       cap_blk_done;
    logic       fet_blk_done;

    assign cap_req = cap_cyc && cap_stb;
    assign fet_req = fet_cyc && fet_stb;

    assign fet_permit = (pend_count != '0) && !xfer_done && (fifo_free >= ROOM_NEEDED);

    capfetch_fsm #(
        .BLOCK_WORDS(BLOCK_WORDS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_req      (cap_req),
        .fet_req      (fet_req),
        .fet_permit   (fet_permit),
        .mem_ack      (mem_ack),
        .state        (state),
        .burst_end    (burst_end),
        .cap_blk_done (cap_blk_done),
        .fet_blk_done (fet_blk_done)
    );

    capfetch_blkcnt #(
        .PEND_W(PEND_W)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cap_blk_done),
        .dec   (fet_blk_done),
        .count (pend_count)
    );

    capfetch_xfer #(
        .XFER_W(XFER_W)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (total_blocks),
        .dec      (fet_blk_done),
        .done     (xfer_done)
    );

    // port steering follows the grant state
    always_comb begin
        mem_cyc  = 1'b0;
        mem_stb  = 1'b0;
        mem_we   = 1'b0;
        mem_adr  = '0;
        cap_ack  = 1'b0;
        fet_ack  = 1'b0;
        unique case (state)
            ARB_IDLE: ;
            ARB_CAPTURE: begin
                mem_cyc = cap_cyc;
                mem_stb = cap_stb;
                mem_we  = 1'b1;
                mem_adr = cap_adr;
                cap_ack = mem_ack;
            end
            ARB_FETCH: begin
                mem_cyc = fet_cyc;
                mem_stb = fet_stb;
                mem_adr = fet_adr;
                fet_ack = mem_ack;
            end
            default: ;
        endcase
    end

    assign mem_wdat = cap_dat;
    assign fet_dat  = mem_rdat;

endmodule

// File: rtl/capfetch_chk.sv
module capfetch_chk
    import capfetch_pkg::*;
#(
    parameter int PEND_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input arb_state_t        state,
    input logic              cap_req,
    input logic              fet_permit,
    input logic              burst_end,
    input logic              cap_ack,
    input logic              fet_ack,
    input logic              cap_blk_done,
    input logic              fet_blk_done,
    input logic [PEND_W-1:0] pend_count,
    input logic              xfer_done
);

    assert_cap_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && cap_req) |=> (state == ARB_CAPTURE));

    assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ARB_IDLE && !burst_end) |=> (state == $past(state)));

    assert_single_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ack && fet_ack));

    assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_blk_done && !fet_blk_done && !(&pend_count))
        |=> (pend_count == PEND_W'($past(pend_count) + 1'b1)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fet_blk_done |-> (pend_count != '0));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fet_blk_done && !cap_blk_done)
        |=> (pend_count == PEND_W'($past(pend_count) - 1'b1)));

    assert_fetch_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && !fet_permit) |=> (state != ARB_FETCH));

    assert_done_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !fet_permit);

endmodule

bind capfetch_arbiter capfetch_chk #(
    .PEND_W(PEND_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .cap_req      (cap_req),
    .fet_permit   (fet_permit),
    .burst_end    (burst_end),
    .cap_ack      (cap_ack),
    .fet_ack      (fet_ack),
    .cap_blk_done (cap_blk_done),
    .fet_blk_done (fet_blk_done),
    .pend_count   (pend_count),
    .xfer_done    (xfer_done)
);

// File: tb/tb_capfetch_arbiter.sv
module tb_capfetch_arbiter;

    localparam int BW     = 8;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int PEND_W = 16;
    localparam int XFER_W = 32;
    localparam int FREE_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [XFER_W-1:0] total_blocks;
    logic [FREE_W-1:0] fifo_free;
    logic              cap_cyc, cap_stb, cap_ack;
    logic [ADDR_W-1:0] cap_adr;
    logic [DATA_W-1:0] cap_dat;
    logic              fet_cyc, fet_stb, fet_ack, fet_permit;
    logic [ADDR_W-1:0] fet_adr;
    logic [DATA_W-1:0] fet_dat;
    logic              mem_cyc, mem_stb, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_adr;
    logic [DATA_W-1:0] mem_wdat, mem_rdat;
    logic [PEND_W-1:0] pend_count;
    logic              xfer_done;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    // zero-wait memory model
    assign mem_ack  = mem_cyc && mem_stb;
    assign mem_rdat = 32'hA5A5_0000;

    capfetch_arbiter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_blocks(total_blocks),
        .fifo_free(fifo_free),
        .cap_cyc(cap_cyc), .cap_stb(cap_stb), .cap_adr(cap_adr), .cap_dat(cap_dat),
        .cap_ack(cap_ack),
        .fet_cyc(fet_cyc), .fet_stb(fet_stb), .fet_adr(fet_adr), .fet_dat(fet_dat),
        .fet_ack(fet_ack), .fet_permit(fet_permit),
        .mem_cyc(mem_cyc), .mem_stb(mem_stb), .mem_we(mem_we), .mem_adr(mem_adr),
        .mem_wdat(mem_wdat), .mem_rdat(mem_rdat), .mem_ack(mem_ack),
        .pend_count(pend_count), .xfer_done(xfer_done)
    );

    // columns: blocks captured, total_blocks, fifo_free, expected permit
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{0, 4,   8, 0},
        '{1, 0,   8, 0},
        '{1, 4,   7, 0},
        '{1, 4,   8, 1},
        '{2, 1, 200, 1},
        '{3, 5,   0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; total_blocks = '0; fifo_free = '0;
        cap_cyc = 1'b0; cap_stb = 1'b0; cap_adr = 16'h0100; cap_dat = 32'h1234_5678;
        fet_cyc = 1'b0; fet_stb = 1'b0; fet_adr = 16'h0200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_start(input int n);
        start = 1'b1; total_blocks = XFER_W'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic one_block(input bit cap);
        int cnt = 0;
        int g = 0;
        if (cap) begin cap_cyc = 1'b1; cap_stb = 1'b1; end
        else     begin fet_cyc = 1'b1; fet_stb = 1'b1; end
        while (cnt < BW && g < 100) begin
            @(negedge clk);
            g++;
            if (cap ? cap_ack : fet_ack) cnt++;
        end
        @(negedge clk);
        cap_cyc = 1'b0; cap_stb = 1'b0; fet_cyc = 1'b0; fet_stb = 1'b0;
    endtask

    // fetch raised at once; capture raised after d negedges (0: same time)
    task automatic run_both(input int d, input int exp_first, input string req);
        int wc = 0;
        int rc = 0;
        int first = -1;
        int order_ok = 1;
        int g = 0;
        fet_cyc = 1'b1; fet_stb = 1'b1;
        if (d == 0) begin cap_cyc = 1'b1; cap_stb = 1'b1; end
        while ((wc < BW || rc < BW) && g < 200) begin
            @(negedge clk);
            g++;
            if (wc == BW) begin cap_cyc = 1'b0; cap_stb = 1'b0; end
            if (rc == BW) begin fet_cyc = 1'b0; fet_stb = 1'b0; end
            if (g == d) begin cap_cyc = 1'b1; cap_stb = 1'b1; end
            if (cap_ack && fet_ack) order_ok = 0;
            if (cap_ack) begin
                if (first < 0) first = 0;
                if (rc != 0 && rc != BW) order_ok = 0;
                wc++;
            end
            if (fet_ack) begin
                if (first < 0) first = 1;
                if (wc != 0 && wc != BW) order_ok = 0;
                rc++;
            end
        end
        @(negedge clk);
        cap_cyc = 1'b0; cap_stb = 1'b0; fet_cyc = 1'b0; fet_stb = 1'b0;
        check({req, " first master (0 capture, 1 fetch)"}, first, exp_first);
        check("R3 bursts not interleaved", order_ok, 1);
    endtask

    initial begin
        int seen;
        do_reset();
        check("R1 mem_cyc after reset", int'(mem_cyc), 0);
        check("R1 pend_count after reset", int'(pend_count), 0);
        check("R1 xfer_done after reset", int'(xfer_done), 1);
        check("R1 fet_permit after reset", int'(fet_permit), 0);

        // permit table, R6
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            do_start(VEC[i][1]);
            for (int b = 0; b < VEC[i][0]; b++) one_block(1'b1);
            fifo_free = FREE_W'(VEC[i][2]);
            @(negedge clk);
            check($sformatf("R6 permit row %0d", i), int'(fet_permit), VEC[i][3]);
            check($sformatf("R4 pend after captures row %0d", i), int'(pend_count), VEC[i][0]);
        end

        // directed corner cases
        do_reset();
        do_start(3);
        fifo_free = 12'd64;
        one_block(1'b1);
        check("R4 pend after one capture", int'(pend_count), 1);

        // R7: fetch asked while FIFO lacks room
        fifo_free = 12'd4;
        fet_cyc = 1'b1; fet_stb = 1'b1;
        seen = 0;
        repeat (5) begin
            @(negedge clk);
            if (fet_ack || mem_cyc) seen = 1;
        end
        fet_cyc = 1'b0; fet_stb = 1'b0;
        check("R7 no grant without permit", seen, 0);
        fifo_free = 12'd64;
        @(negedge clk);

        run_both(0, 0, "R2 simultaneous");
        check("R5 pend after capture+fetch pair", int'(pend_count), 1);
        check("R8 transfer not done after one fetch", int'(xfer_done), 0);

        run_both(3, 1, "R3 capture arrives mid-fetch");
        check("R5 pend after second pair", int'(pend_count), 1);

        one_block(1'b0);
        check("R5 pend after lone fetch", int'(pend_count), 0);
        check("R8 done after last block", int'(xfer_done), 1);

        one_block(1'b1);
        check("R9 capture counted while done", int'(pend_count), 1);
        check("R8 permit low while done", int'(fet_permit), 0);

        do_start(2);
        @(negedge clk);
        check("R8 reload clears done", int'(xfer_done), 0);
        check("R6 permit after reload", int'(fet_permit), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule